// File: doc/BRIEF.md
# Graphics DMA Address Cutoff Guard

This block decides, for every request a graphics DMA master makes, whether the addressed bytes lie in memory the master may reach. A single 32-bit control word sets the limits. It holds a main-memory cutoff count, an extended-memory cutoff count, a work-RAM lock flag and a secondary-memory cutoff count. Each cutoff count protects a window that is anchored at the top of its region and grows downward in fixed steps. The main-memory count also protects the lowest step of the extended region.

A request carries a start address and a byte count. The guard raises `req_deny` in the same cycle as `req_valid` when any byte of the request touches an active protected window. The control word is written through a plain write strobe and can always be read back. Writes take effect from the next clock edge. After reset the control word is zero and nothing is protected.

Top module: `dma_cutoff_guard`

## Requirements
- R1: After reset the control word reads 0, and with a zero control word no request is denied.
- R2: Control bits 10:0 keep the value last written. Bits 31:11 always read as zero.
- R3: With main cutoff x = bits 3:0 non-zero, any byte in [0x28000000 - x*0x800000, 0x28000000) is denied. With x = 0 that window is open.
- R4: The lowest 8 MiB of main memory, [0x20000000, 0x20800000), is never denied by the main cutoff, even at x = 15.
- R5: With extended cutoff y = bits 7:4 non-zero, any byte in [0x30000000 - y*0x800000, 0x30000000) is denied.
- R6: When x is non-zero, the first 8 MiB of extended memory, [0x28000000, 0x28800000), is also denied. When x is zero, that window is open unless y covers it.
- R7: The main and extended cutoffs act together. A byte is denied if either window covers it.
- R8: With bit 8 set, every byte of work RAM, [0x1FF80000, 0x20000000), is denied. With bit 8 clear, work RAM is open.
- R9: With secondary cutoff z = bits 10:9 non-zero, any byte in [0x1F400000 - z*0x100000, 0x1F400000) is denied.
- R10: A request covers `req_len`+1 bytes starting at `req_addr`. It is denied if any one of those bytes is protected, including when only its last byte crosses into a window.
- R11: `req_deny` is combinational with the request. It is valid in the same cycle as `req_valid` and is low whenever `req_valid` is low.
- R12: A control write takes effect from the clock edge that ends the write cycle. A request in the write cycle itself is judged against the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback, upper bits zero |
| req_valid | input | 1 | DMA request present this cycle |
| req_addr | input | 32 | First byte address of the request |
| req_len | input | LEN_W (8) | Request byte count minus one |
| req_deny | output | 1 | Request touches a protected window |

## Verification
The embedded properties check the following on every cycle:
- the deny stays low with no request (R11) and with a zero control word (R1);
- a written value lands in the control word on the next edge (R12);
- any request inside work RAM is refused while the lock bit is set (R8);
- the derived main window never reaches below its protected floor (R4).

The exact window edges can only be shown by the bench's scenarios. These cover each cutoff count at small and maximal settings, the extended-head overlap and its combination with the extended cutoff, multi-byte requests whose last byte crosses a boundary, and requests in the same cycle as a control write.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;

  localparam int unsigned AW = 32;
  localparam int unsigned XW = AW + 1;
  localparam int unsigned REG_W = 32;

  localparam int unsigned MAIN_LSB = 0;
  localparam int unsigned MAIN_FW  = 4;
  localparam int unsigned EXT_LSB  = MAIN_LSB + MAIN_FW;
  localparam int unsigned EXT_FW   = 4;
  localparam int unsigned WRAM_BIT = EXT_LSB + EXT_FW;
  localparam int unsigned SEC_LSB  = WRAM_BIT + 1;
  localparam int unsigned SEC_FW   = 2;
  localparam int unsigned KEEP_W   = SEC_LSB + SEC_FW;

  typedef enum int unsigned {
    SPAN_MAIN     = 0,
    SPAN_EXT_HEAD = 1,
    SPAN_EXT      = 2,
    SPAN_WRAM     = 3,
    SPAN_SEC      = 4
  } span_id_e;

  localparam int unsigned SPAN_N = 5;

  typedef struct packed {
    logic          en;
    logic [XW-1:0] lo;
    logic [XW-1:0] hi;
  } span_t;

endpackage

// File: rtl/dma_guard_cfg.sv
module dma_guard_cfg
  import dma_guard_pkg::*;
#(
  parameter int unsigned KEEP = KEEP_W,
  parameter int unsigned RW   = REG_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RW-1:0]   wdata,
  output logic [KEEP-1:0] cfg,
  output logic [RW-1:0]   rdata
);

  localparam int unsigned PAD = RW - KEEP;

  logic [KEEP-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q <= wdata[KEEP-1:0];
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {{PAD{1'b0}}, cfg_q};

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we)) |-> (cfg == $past(wdata[KEEP-1:0]))); // R12

endmodule

// File: rtl/dma_guard_spans.sv
module dma_guard_spans
  import dma_guard_pkg::*;
#(
  parameter logic [AW-1:0] MAIN_BASE  = 32'h2000_0000,
  parameter logic [AW-1:0] MAIN_END   = 32'h2800_0000,
  parameter logic [AW-1:0] EXT_BASE   = 32'h2800_0000,
  parameter logic [AW-1:0] EXT_END    = 32'h3000_0000,
  parameter logic [AW-1:0] WRAM_BASE  = 32'h1FF8_0000,
  parameter logic [AW-1:0] WRAM_BYTES = 32'h0008_0000,
  parameter logic [AW-1:0] SEC_END    = 32'h1F40_0000,
  parameter int unsigned   BIG_SHIFT  = 23,
  parameter int unsigned   SEC_SHIFT  = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [KEEP_W-1:0]      cfg,
  output span_t [SPAN_N-1:0]     spans
);

  localparam logic [XW-1:0] BIG_STEP = XW'(1) << BIG_SHIFT;

  logic [MAIN_FW-1:0] main_cnt;
  logic [EXT_FW-1:0]  ext_cnt;
  logic [SEC_FW-1:0]  sec_cnt;
  logic               wram_lock;

  assign main_cnt  = cfg[MAIN_LSB +: MAIN_FW];
  assign ext_cnt   = cfg[EXT_LSB +: EXT_FW];
  assign sec_cnt   = cfg[SEC_LSB +: SEC_FW];
  assign wram_lock = cfg[WRAM_BIT];

  always_comb begin
    spans = '0;

    spans[SPAN_MAIN].en = (main_cnt != '0);
    spans[SPAN_MAIN].lo = XW'(MAIN_END) - (XW'(main_cnt) << BIG_SHIFT);
    spans[SPAN_MAIN].hi = XW'(MAIN_END);

    spans[SPAN_EXT_HEAD].en = (main_cnt != '0);
    spans[SPAN_EXT_HEAD].lo = XW'(EXT_BASE);
    spans[SPAN_EXT_HEAD].hi = XW'(EXT_BASE) + BIG_STEP;

    spans[SPAN_EXT].en = (ext_cnt != '0);
    spans[SPAN_EXT].lo = XW'(EXT_END) - (XW'(ext_cnt) << BIG_SHIFT);
    spans[SPAN_EXT].hi = XW'(EXT_END);

    spans[SPAN_WRAM].en = wram_lock;
    spans[SPAN_WRAM].lo = XW'(WRAM_BASE);
    spans[SPAN_WRAM].hi = XW'(WRAM_BASE) + XW'(WRAM_BYTES);

    spans[SPAN_SEC].en = (sec_cnt != '0);
    spans[SPAN_SEC].lo = XW'(SEC_END) - (XW'(sec_cnt) << SEC_SHIFT);
    spans[SPAN_SEC].hi = XW'(SEC_END);
  end

  AST_MAIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    spans[SPAN_MAIN].en |-> (spans[SPAN_MAIN].lo >= (XW'(MAIN_BASE) + BIG_STEP))); // R4

endmodule

// File: rtl/dma_guard_hit.sv
module dma_guard_hit
  import dma_guard_pkg::*;
(
  input  logic [XW-1:0] req_lo,
  input  logic [XW-1:0] req_hi,
  input  span_t         span,
  output logic          hit
);

  always_comb begin
    hit = span.en && (req_lo < span.hi) && (req_hi > span.lo);
  end

endmodule

// File: rtl/dma_cutoff_guard.sv
module dma_cutoff_guard
  import dma_guard_pkg::*;
#(
  parameter int unsigned   LEN_W      = 8,
  parameter logic [AW-1:0] MAIN_BASE  = 32'h2000_0000,
  parameter logic [AW-1:0] MAIN_END   = 32'h2800_0000,
  parameter logic [AW-1:0] EXT_BASE   = 32'h2800_0000,
  parameter logic [AW-1:0] EXT_END    = 32'h3000_0000,
  parameter logic [AW-1:0] WRAM_BASE  = 32'h1FF8_0000,
  parameter logic [AW-1:0] WRAM_BYTES = 32'h0008_0000,
  parameter logic [AW-1:0] SEC_END    = 32'h1F40_0000,
  parameter int unsigned   BIG_SHIFT  = 23,
  parameter int unsigned   SEC_SHIFT  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_deny
);

  localparam logic [XW-1:0] LOW_SAFE_END = XW'(MAIN_BASE) + (XW'(1) << BIG_SHIFT);

  logic [KEEP_W-1:0]   cfg;
  span_t [SPAN_N-1:0]  spans;
  logic [SPAN_N-1:0]   hits;
  logic [XW-1:0]       req_lo;
  logic [XW-1:0]       req_hi;

  dma_guard_cfg #(
    .KEEP (KEEP_W),
    .RW   (REG_W)
  ) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  dma_guard_spans #(
    .MAIN_BASE  (MAIN_BASE),
    .MAIN_END   (MAIN_END),
    .EXT_BASE   (EXT_BASE),
    .EXT_END    (EXT_END),
    .WRAM_BASE  (WRAM_BASE),
    .WRAM_BYTES (WRAM_BYTES),
    .SEC_END    (SEC_END),
    .BIG_SHIFT  (BIG_SHIFT),
    .SEC_SHIFT  (SEC_SHIFT)
  ) u_spans (
    .clk   (clk),
    .rst   (rst),
    .cfg   (cfg),
    .spans (spans)
  );

  assign req_lo = {1'b0, req_addr};
  assign req_hi = {1'b0, req_addr} + XW'(req_len) + XW'(1);

  for (genvar g = 0; g < SPAN_N; g++) begin : g_hit
    dma_guard_hit u_hit (
      .req_lo (req_lo),
      .req_hi (req_hi),
      .span   (spans[g]),
      .hit    (hits[g])
    );
  end

  assign req_deny = req_valid && (|hits);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !req_deny); // R11

  AST_ZERO_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata == '0) |-> !req_deny); // R1

  AST_LOW_MAIN_OPEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_lo >= XW'(MAIN_BASE)) && (req_hi <= LOW_SAFE_END)) |-> !req_deny); // R4

  AST_WRAM_LOCK: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cfg_rdata[WRAM_BIT] && (req_lo >= XW'(WRAM_BASE))
     && (req_lo < (XW'(WRAM_BASE) + XW'(WRAM_BYTES)))) |-> req_deny); // R8

endmodule

// File: tb/sim_dma_cutoff_guard.sv
`timescale 1ns/1ps
module sim_dma_cutoff_guard;

  localparam int LEN_W = 8;
  localparam longint M_END   = 64'h2800_0000;
  localparam longint M_BASE  = 64'h2000_0000;
  localparam longint E_END   = 64'h3000_0000;
  localparam longint STEP    = 64'h80_0000;
  localparam longint W_BASE  = 64'h1FF8_0000;
  localparam longint W_SIZE  = 64'h8_0000;
  localparam longint S_END   = 64'h1F40_0000;
  localparam longint S_STEP  = 64'h10_0000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic             req_valid = 1'b0;
  logic [31:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_deny;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model_cfg = '0;

  typedef struct {
    bit          exp;
    logic [31:0] addr;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  dma_cutoff_guard #(.LEN_W(LEN_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_deny  (req_deny)
  );

  function automatic bit ovl(longint a, longint b, longint lo, longint hi);
    return (a < hi) && (b > lo);
  endfunction

  function automatic bit ref_deny(logic [31:0] c, logic [31:0] addr, int len);
    longint a = longint'(addr);
    longint b = a + longint'(len) + 1;
    longint x = longint'(c[3:0]);
    longint y = longint'(c[7:4]);
    longint z = longint'(c[10:9]);
    bit d = 1'b0;
    if (x != 0 && ovl(a, b, M_END - x*STEP, M_END)) d = 1'b1;
    if (x != 0 && ovl(a, b, M_END, M_END + STEP)) d = 1'b1;
    if (y != 0 && ovl(a, b, E_END - y*STEP, E_END)) d = 1'b1;
    if (c[8] && ovl(a, b, W_BASE, W_BASE + W_SIZE)) d = 1'b1;
    if (z != 0 && ovl(a, b, S_END - z*S_STEP, S_END)) d = 1'b1;
    return d;
  endfunction

  // Driver: one cycle per call, expected result pushed before the edge.
  task automatic drive(bit we, logic [31:0] wd, bit v, logic [31:0] a, int len, string tag);
    @(posedge clk); #1;
    cfg_we    = we;
    cfg_wdata = wd;
    req_valid = v;
    req_addr  = a;
    req_len   = LEN_W'(len);
    if (v) begin
      item_t it;
      it.exp  = ref_deny(model_cfg, a, len);
      it.addr = a;
      it.tag  = tag;
      sb.push_back(it);
    end
    if (we) model_cfg = wd & 32'h0000_07FF;
  endtask

  task automatic wr(logic [31:0] wd);
    drive(1'b1, wd, 1'b0, 32'h0, 0, "");
  endtask

  task automatic probe(logic [31:0] a, int len, string tag);
    drive(1'b0, 32'h0, 1'b1, a, len, tag);
  endtask

  task automatic idle_at(logic [31:0] a);
    drive(1'b0, 32'h0, 1'b0, a, 0, "");
  endtask

  task automatic rd_check(logic [31:0] exp, string tag);
    @(negedge clk);
    checks++;
    if (cfg_rdata !== exp) begin
      fails++;
      $display("FAIL %s readback actual=%h expected=%h", tag, cfg_rdata, exp);
    end
  endtask

  // Monitor: samples on the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (req_valid) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL scoreboard empty actual=%b expected=none", req_deny);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (req_deny !== it.exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%b expected=%b", it.tag, it.addr, req_deny, it.exp);
          end
        end
      end else begin
        checks++;
        if (req_deny !== 1'b0) begin
          fails++;
          $display("FAIL R11 idle deny actual=%b expected=0", req_deny);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    rd_check(32'h0, "R1");
    probe(32'h27FF_FFFF, 0, "R1");
    probe(32'h1FF8_0000, 0, "R1");
    probe(32'h1F3F_FFFF, 0, "R1");
    probe(32'h2FFF_FFFF, 0, "R1");

    // R2: readback masks upper bits
    wr(32'hFFFF_FFFF);
    idle_at(32'h0);
    rd_check(32'h0000_07FF, "R2");
    wr(32'h0000_0000);
    idle_at(32'h0);
    rd_check(32'h0, "R2");

    // R3, R6: main cutoff one step
    wr(32'h0000_0001);
    probe(32'h2780_0000, 0, "R3");
    probe(32'h277F_FFFF, 0, "R3");
    probe(32'h27FF_FFFF, 0, "R3");
    probe(32'h2800_0000, 0, "R6");
    probe(32'h287F_FFFF, 0, "R6");
    probe(32'h2880_0000, 0, "R6");

    // R4: max main cutoff leaves lowest 8 MiB open
    wr(32'h0000_000F);
    probe(32'h2080_0000, 0, "R4");
    probe(32'h207F_FFFF, 0, "R4");
    probe(32'h2000_0000, 0, "R4");

    // R5, R6: extended only
    wr(32'h0000_0020);
    probe(32'h2F00_0000, 0, "R5");
    probe(32'h2EFF_FFFF, 0, "R5");
    probe(32'h2FFF_FFFF, 0, "R5");
    probe(32'h2800_0000, 0, "R6");

    // R7: combined
    wr(32'h0000_0043);
    probe(32'h2680_0000, 0, "R7");
    probe(32'h267F_FFFF, 0, "R7");
    probe(32'h2800_0000, 0, "R7");
    probe(32'h2880_0000, 0, "R7");
    probe(32'h2E00_0000, 0, "R7");
    probe(32'h2DFF_FFFF, 0, "R7");
    wr(32'h0000_00F1);
    probe(32'h2880_0000, 0, "R7");
    probe(32'h2840_0000, 0, "R7");

    // R8: work RAM lock
    wr(32'h0000_0100);
    probe(32'h1FF8_0000, 0, "R8");
    probe(32'h1FFF_FFFF, 0, "R8");
    probe(32'h1FF7_FFFF, 0, "R8");
    probe(32'h2000_0000, 0, "R8");
    wr(32'h0000_0000);
    probe(32'h1FF8_0000, 0, "R8");

    // R9: secondary cutoff
    wr(32'h0000_0600);
    probe(32'h1F10_0000, 0, "R9");
    probe(32'h1F0F_FFFF, 0, "R9");
    probe(32'h1F3F_FFFF, 0, "R9");
    probe(32'h1F40_0000, 0, "R9");
    wr(32'h0000_0200);
    probe(32'h1F30_0000, 0, "R9");
    probe(32'h1F2F_FFFF, 0, "R9");

    // R10: multi-byte requests crossing into a window
    probe(32'h1F2F_FF00, 255, "R10");
    probe(32'h1F2F_FF01, 255, "R10");
    wr(32'h0000_0001);
    probe(32'h277F_FFFC, 3, "R10");
    probe(32'h277F_FFFC, 4, "R10");
    probe(32'h207F_FF00, 255, "R10");

    // R11: no deny without a request, even at a protected address
    idle_at(32'h27FF_FFFF);
    idle_at(32'h2800_0000);

    // R12: request in the write cycle uses the old value
    drive(1'b1, 32'h0000_0000, 1'b1, 32'h27FF_FFFF, 0, "R12");
    probe(32'h27FF_FFFF, 0, "R12");
    drive(1'b1, 32'h0000_0100, 1'b1, 32'h1FF8_0000, 0, "R12");
    probe(32'h1FF8_0000, 0, "R12");

    idle_at(32'h0);
    idle_at(32'h0);
    @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule